// File: doc/BRIEF.md
# GPIO Interrupt-on-Change Unit

This unit watches a port of general-purpose input pins and raises an interrupt when an enabled pin meets its trigger condition. The pins first pass through a synchronizer. Each pin then works in one of two modes. In edge mode it fires when its synchronized level differs from the level seen one cycle earlier. In level mode it fires for as long as its level differs from a programmed reference bit.

When the first trigger arrives, the unit becomes pending. It records which single pin caused the interrupt and takes a snapshot of the whole port. Both records stay frozen until software clears the interrupt. The clear comes from a read strobe: a read of the live port value, or, in the other clear mode, a read of the snapshot.

The interrupt pin can be driven push-pull with either polarity. It can also be driven open-drain: the output enable is active only while pending, and the data is held low. Register decode and the host bus sit outside this unit. The register contents arrive as plain inputs, and the read strobes arrive as one-cycle pulses.

Top module: `gpio_ioc_unit`

## Requirements
- R1: A pin whose bit in `irq_en` is 0 never causes the unit to become pending and never sets its bit in `flag_o`.
- R2: In edge mode (`cmp_mode` bit = 0), a change on `pin_async` makes the unit pending exactly SYNC_STAGES+1 rising clock edges after the change. With the default of 2 stages, this is the third edge.
- R3: In level mode (`cmp_mode` bit = 1), the pin triggers while its synchronized level differs from its `ref_val` bit. A change of `ref_val` makes the unit pending at the next rising edge.
- R4: While pending, `flag_o` has exactly one bit set: the lowest-numbered triggering pin of the capturing cycle. While idle, `flag_o` is 0.
- R5: `cap_o` takes the synchronized port value in the cycle the interrupt is captured. It holds that value while pending and after the clear, until the next capture. It resets to 0.
- R6: Further triggers while pending change neither `flag_o` nor `cap_o`.
- R7: With `cfg_clr_on_cap` = 0, a one-cycle `rd_port` pulse ends the pending state at that edge and `rd_cap` is ignored. With `cfg_clr_on_cap` = 1, the roles of the two strobes swap.
- R8: A clear takes priority over a capture in the same cycle. A level-mode pin that still differs from its reference makes the unit pending again one edge after the clear.
- R9: With `cfg_open_drain` = 0, `irq_oe` is 1. `irq_o` equals the pending state when `cfg_act_high` = 1 and its inverse when `cfg_act_high` = 0.
- R10: With `cfg_open_drain` = 1, `irq_o` is 0 and `irq_oe` equals the pending state, whatever the value of `cfg_act_high`.
- R11: After reset, the unit is idle, `flag_o`, `cap_o` and `port_o` are 0, and the synchronizer and previous-value registers are 0.
- R12: `port_o` shows the synchronized pin levels SYNC_STAGES edges after a change on `pin_async`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_async | input | NPINS | Raw pin levels |
| irq_en | input | NPINS | Per-pin interrupt enable |
| cmp_mode | input | NPINS | Per-pin mode: 0 edge, 1 level against reference |
| ref_val | input | NPINS | Per-pin reference level for level mode |
| cfg_clr_on_cap | input | 1 | 1: capture read clears; 0: port read clears |
| cfg_act_high | input | 1 | Push-pull polarity, 1 = active high |
| cfg_open_drain | input | 1 | 1: open-drain drive of the interrupt pin |
| rd_port | input | 1 | One-cycle strobe: port value is read |
| rd_cap | input | 1 | One-cycle strobe: capture value is read |
| port_o | output | NPINS | Synchronized pin levels |
| flag_o | output | NPINS | One-hot cause of the pending interrupt |
| cap_o | output | NPINS | Port snapshot taken at capture |
| irq_o | output | 1 | Interrupt pin data |
| irq_oe | output | 1 | Interrupt pin output enable |

## Verification
A pin edge reaches the pending state after SYNC_STAGES+1 edges: the synchronizer stages plus the capture register. A reference change or a clear strobe acts after one edge, and the interrupt pin follows the pending state and the configuration bits with no delay. The bench drives all inputs at the falling edge. It advances a counted number of rising edges derived from these latencies and samples on the following falling edge. For the edge and clear delays, it also checks one edge early that nothing has happened yet. This pins down the exact cycle, not just the eventual value.

// File: rtl/gpio_ioc_pkg.sv
package gpio_ioc_pkg;
   typedef struct packed {
      logic clr_on_cap;
      logic act_high;
      logic open_drain;
   } ioc_cfg_t;

   typedef enum logic [1:0] {
      DRV_PUSH_LOW  = 2'b00,
      DRV_PUSH_HIGH = 2'b01,
      DRV_OPEN      = 2'b10
   } ioc_drive_e;
endpackage

// File: rtl/gpio_ioc_sync.sv
module gpio_ioc_sync #(
   parameter int NPINS       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] raw_i,
   output logic [NPINS-1:0] sync_o
);
   generate
      if (SYNC_STAGES == 0) begin : g_bypass
         assign sync_o = raw_i;
      end else begin : g_chain
         logic [SYNC_STAGES-1:0][NPINS-1:0] stage_q;
         for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
               always_ff @(posedge clk or negedge rst_n) begin
                  if (!rst_n) stage_q[s] <= '0;
                  else        stage_q[s] <= raw_i;
               end
            end else begin : g_next
               always_ff @(posedge clk or negedge rst_n) begin
                  if (!rst_n) stage_q[s] <= '0;
                  else        stage_q[s] <= stage_q[s-1];
               end
            end
         end
         assign sync_o = stage_q[SYNC_STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/gpio_ioc_detect.sv
module gpio_ioc_detect #(
   parameter int NPINS = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] level_i,
   input  logic [NPINS-1:0] en_i,
   input  logic [NPINS-1:0] mode_i,
   input  logic [NPINS-1:0] ref_i,
   output logic [NPINS-1:0] trig_o
);
   logic [NPINS-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= level_i;
   end

   for (genvar p = 0; p < NPINS; p++) begin : g_pin
      logic differs;
      assign differs   = mode_i[p] ? (level_i[p] ^ ref_i[p]) : (level_i[p] ^ prev_q[p]);
      assign trig_o[p] = en_i[p] & differs;
   end

   // R2: an edge-mode trigger needs a level change against the prior cycle
   a_r2_edge_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
      ((trig_o & ~mode_i) != '0) |-> ((level_i ^ prev_q) != '0));
endmodule

// File: rtl/gpio_ioc_latch.sv
module gpio_ioc_latch #(
   parameter int NPINS = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] trig_i,
   input  logic [NPINS-1:0] level_i,
   input  logic             clr_i,
   output logic             pending_o,
   output logic [NPINS-1:0] flag_o,
   output logic [NPINS-1:0] cap_o
);
   localparam logic [NPINS-1:0] ONE = {{(NPINS-1){1'b0}}, 1'b1};

   logic [NPINS-1:0] first_hit;
   logic             take;

   assign first_hit = trig_i & (~trig_i + ONE);
   assign take      = !pending_o && !clr_i && (trig_i != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending_o <= 1'b0;
         flag_o    <= '0;
         cap_o     <= '0;
      end else if (clr_i) begin
         pending_o <= 1'b0;
         flag_o    <= '0;
      end else if (take) begin
         pending_o <= 1'b1;
         flag_o    <= first_hit;
         cap_o     <= level_i;
      end
   end

   // R4: one cause bit while pending, none while idle
   a_r4_flag_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      pending_o |-> ($countones(flag_o) == 1));
   a_r4_flag_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !pending_o |-> (flag_o == '0));
   // R5 / R6: snapshot frozen while pending
   a_r6_cap_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (pending_o && !clr_i) |=> ($stable(cap_o) && $stable(flag_o)));
   // R8: clear wins and leaves the unit idle for one cycle
   a_r8_clear_idle: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> !pending_o);
endmodule

// File: rtl/gpio_ioc_drive.sv
module gpio_ioc_drive
   import gpio_ioc_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     active_i,
   input  ioc_cfg_t cfg_i,
   output logic     pin_o,
   output logic     oe_o
);
   ioc_drive_e drv;

   always_comb begin
      if (cfg_i.open_drain)    drv = DRV_OPEN;
      else if (cfg_i.act_high) drv = DRV_PUSH_HIGH;
      else                     drv = DRV_PUSH_LOW;
   end

   always_comb begin
      unique case (drv)
         DRV_OPEN: begin
            pin_o = 1'b0;
            oe_o  = active_i;
         end
         DRV_PUSH_HIGH: begin
            pin_o = active_i;
            oe_o  = 1'b1;
         end
         default: begin
            pin_o = !active_i;
            oe_o  = 1'b1;
         end
      endcase
   end

   // R10: open-drain never drives high
   a_r10_od_low: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_i.open_drain |-> (!pin_o && (oe_o == active_i)));
   // R9: push-pull always enabled
   a_r9_pp_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_i.open_drain |-> oe_o);
endmodule

// File: rtl/gpio_ioc_unit.sv
module gpio_ioc_unit
   import gpio_ioc_pkg::*;
#(
   parameter int NPINS       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] pin_async,
   input  logic [NPINS-1:0] irq_en,
   input  logic [NPINS-1:0] cmp_mode,
   input  logic [NPINS-1:0] ref_val,
   input  logic             cfg_clr_on_cap,
   input  logic             cfg_act_high,
   input  logic             cfg_open_drain,
   input  logic             rd_port,
   input  logic             rd_cap,
   output logic [NPINS-1:0] port_o,
   output logic [NPINS-1:0] flag_o,
   output logic [NPINS-1:0] cap_o,
   output logic             irq_o,
   output logic             irq_oe
);
   generate
      if (NPINS < 1 || NPINS > 32) begin : g_bad_width
         $error("gpio_ioc_unit: NPINS must lie in 1..32");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("gpio_ioc_unit: SYNC_STAGES must lie in 0..4");
      end
   endgenerate

   ioc_cfg_t         cfg;
   logic [NPINS-1:0] level;
   logic [NPINS-1:0] trig;
   logic             clr_evt;
   logic             pending;

   assign cfg     = '{clr_on_cap: cfg_clr_on_cap, act_high: cfg_act_high,
                      open_drain: cfg_open_drain};
   assign clr_evt = cfg.clr_on_cap ? rd_cap : rd_port;
   assign port_o  = level;

   gpio_ioc_sync #(.NPINS(NPINS), .SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .raw_i(pin_async), .sync_o(level));

   gpio_ioc_detect #(.NPINS(NPINS)) u_detect (
      .clk(clk), .rst_n(rst_n), .level_i(level), .en_i(irq_en),
      .mode_i(cmp_mode), .ref_i(ref_val), .trig_o(trig));

   gpio_ioc_latch #(.NPINS(NPINS)) u_latch (
      .clk(clk), .rst_n(rst_n), .trig_i(trig), .level_i(level),
      .clr_i(clr_evt), .pending_o(pending), .flag_o(flag_o), .cap_o(cap_o));

   gpio_ioc_drive u_drive (
      .clk(clk), .rst_n(rst_n), .active_i(pending), .cfg_i(cfg),
      .pin_o(irq_o), .oe_o(irq_oe));

   // R1: a newly latched cause is always an enabled pin
   a_r1_enabled_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pending) |-> ((flag_o & ~$past(irq_en)) == '0));
   // R5: the snapshot is the port level of the capturing cycle
   a_r5_cap_value: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pending) |-> (cap_o == $past(level)));
   // R7: the unselected strobe leaves a pending interrupt alone
   a_r7_other_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (pending && !(cfg_clr_on_cap ? rd_cap : rd_port)) |=> pending);
endmodule

// File: tb/gpio_ioc_unit_test.sv
module gpio_ioc_unit_test;
   localparam int N   = 8;
   localparam int SS  = 2;
   localparam int LAT = SS + 1;

   logic         clk = 1'b0;
   logic         rst_n;
   logic [N-1:0] pin_async, irq_en, cmp_mode, ref_val;
   logic         cfg_clr_on_cap, cfg_act_high, cfg_open_drain, rd_port, rd_cap;
   logic [N-1:0] port_o, flag_o, cap_o;
   logic         irq_o, irq_oe;

   int checks = 0;
   int errors = 0;
   logic [N-1:0] pins;
   logic [N-1:0] snap;

   gpio_ioc_unit #(.NPINS(N), .SYNC_STAGES(SS)) uut (
      .clk(clk), .rst_n(rst_n), .pin_async(pin_async), .irq_en(irq_en),
      .cmp_mode(cmp_mode), .ref_val(ref_val), .cfg_clr_on_cap(cfg_clr_on_cap),
      .cfg_act_high(cfg_act_high), .cfg_open_drain(cfg_open_drain),
      .rd_port(rd_port), .rd_cap(rd_cap), .port_o(port_o), .flag_o(flag_o),
      .cap_o(cap_o), .irq_o(irq_o), .irq_oe(irq_oe));

   always #10 clk = ~clk;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic pulse_port();
      rd_port = 1'b1; tick(1); rd_port = 1'b0;
   endtask

   task automatic pulse_cap();
      rd_cap = 1'b1; tick(1); rd_cap = 1'b0;
   endtask

   initial begin
      #1000000;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0; pin_async = '0; irq_en = '0; cmp_mode = '0; ref_val = '0;
      cfg_clr_on_cap = 1'b0; cfg_act_high = 1'b1; cfg_open_drain = 1'b0;
      rd_port = 1'b0; rd_cap = 1'b0; pins = '0;
      tick(3);
      rst_n = 1'b1;
      tick(1);
      // R11 reset state
      check("R11 irq", {irq_oe, irq_o}, 2'b10);
      check("R11 flag", flag_o, 0);
      check("R11 cap", cap_o, 0);
      check("R11 port", port_o, 0);

      irq_en = '1;
      // R2 R4 R5 R12 edge sweep on every pin
      for (int i = 0; i < N; i++) begin
         pins = pins ^ (N'(1) << i);
         pin_async = pins;
         tick(SS);
         check("R12 port", port_o, pins);
         check("R2 not yet", irq_o, 0);
         tick(1);
         check("R2 pending", irq_o, 1);
         check("R4 flag", flag_o, N'(1) << i);
         check("R5 cap", cap_o, pins);
         pulse_port();
         check("R7 cleared", irq_o, 0);
         check("R4 idle flag", flag_o, 0);
         check("R5 cap held", cap_o, pins);
      end

      // R4 lowest-numbered of simultaneous pins
      pins = pins ^ 8'hA8; pin_async = pins; snap = pins;
      tick(LAT);
      check("R4 lowest", flag_o, 8'h08);
      // R6 frozen while pending
      pins = pins ^ 8'h01; pin_async = pins;
      tick(LAT + 1);
      check("R6 flag frozen", flag_o, 8'h08);
      check("R6 cap frozen", cap_o, snap);
      pulse_port();
      tick(2);
      check("R8 edge not re-armed", irq_o, 0);

      // R1 disabled pin ignored
      irq_en = 8'h0F;
      pins = pins ^ 8'h20; pin_async = pins;
      tick(LAT + 2);
      check("R1 disabled", irq_o, 0);
      check("R1 flag", flag_o, 0);
      irq_en = '1;

      // R3 level mode on pin 6
      cmp_mode = 8'h40; ref_val = pins & 8'h40;
      tick(2);
      check("R3 equal", irq_o, 0);
      ref_val = ref_val ^ 8'h40;
      tick(1);
      check("R3 differs", irq_o, 1);
      check("R3 flag", flag_o, 8'h40);
      check("R3 cap", cap_o, pins);
      pulse_port();
      check("R8 clear", irq_o, 0);
      tick(1);
      check("R8 reassert", irq_o, 1);
      ref_val = ref_val ^ 8'h40;
      pulse_port();
      tick(2);
      check("R3 settled", irq_o, 0);
      cmp_mode = '0;

      // R7 capture-read clear mode
      cfg_clr_on_cap = 1'b1;
      pins = pins ^ 8'h04; pin_async = pins;
      tick(LAT);
      check("R7 pending", flag_o, 8'h04);
      pulse_port();
      check("R7 port read ignored", irq_o, 1);
      pulse_cap();
      check("R7 cap read clears", irq_o, 0);

      // R9 R10 drive modes, idle then pending
      cfg_act_high = 1'b0; #1;
      check("R9 low idle", {irq_oe, irq_o}, 2'b11);
      cfg_open_drain = 1'b1; #1;
      check("R10 od idle", {irq_oe, irq_o}, 2'b00);
      pins = pins ^ 8'h80; pin_async = pins;
      tick(LAT);
      check("R10 od pending", {irq_oe, irq_o}, 2'b10);
      cfg_act_high = 1'b1; #1;
      check("R10 od ignores polarity", {irq_oe, irq_o}, 2'b10);
      cfg_open_drain = 1'b0; #1;
      check("R9 high pending", {irq_oe, irq_o}, 2'b11);
      cfg_act_high = 1'b0; #1;
      check("R9 low pending", {irq_oe, irq_o}, 2'b10);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule